// File: doc/BRIEF.md
# Fixed Ratio 19/32 Scaler with Selectable Rounding

This block scales an 8-bit unsigned sample by roughly 0.6. It multiplies the sample by 19 and then divides by 32. The multiply is a sum of three copies of the sample, shifted left by four, by one and by zero places. The divide keeps only the upper eight bits of the 13-bit sum, so it needs no logic. No general multiplier is involved.

A 2-bit select picks how the five discarded bits are treated. The choices are truncation, rounding to nearest with ties going up, or rounding towards the ceiling. The selected offset is added to the sum before the low bits are dropped. One register stage holds the result, and a valid strobe travels alongside it.

Top module: `ratio_scaler`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is asserted, `out_scaled` reads 0 and `out_valid` reads 0.
- R2: With `in_round` = 2'b00 (floor), a sample x accepted with `in_valid` high gives `out_scaled` = floor(19·x/32) after the next rising clock edge.
- R3: With `in_round` = 2'b01 (half-up), the result is floor((19·x+16)/32), so exact half ties round upward.
- R4: With `in_round` = 2'b10 (ceiling), the result is floor((19·x+31)/32).
- R5: With `in_round` = 2'b11, the result is the same as floor mode.
- R6: `out_valid` equals the value `in_valid` had before the most recent rising clock edge.
- R7: A clock edge with `in_valid` low leaves `out_scaled` unchanged, whatever `in_sample` and `in_round` hold.
- R8: The largest case, x = 255 in ceiling mode, gives 152 with no wrap-around, and `out_scaled` never exceeds 152.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| in_valid | input | 1 | Marks the sample and rounding select as valid for this cycle |
| in_sample | input | 8 | Unsigned sample to be scaled |
| in_round | input | 2 | Rounding select: 00 floor, 01 half-up, 10 ceiling, 11 floor |
| out_scaled | output | 8 | Registered scaled result |
| out_valid | output | 1 | High for one cycle for each accepted sample |

## Verification
Every result lands exactly one rising edge after the sample is presented: `out_scaled` and `out_valid` both come from the single register stage. The bench drives inputs on the falling edge. It reads the outputs on the next falling edge, half a cycle after the loading edge, so each reading pairs with the sample presented one cycle earlier. All 256 samples are swept in each of the four select codes against an arithmetic reference. The hold and valid-drop checks are read on the falling edge after an idle cycle, while the changed inputs are still applied.

// File: rtl/ratio_scaler_pkg.sv
package ratio_scaler_pkg;
  typedef enum logic [1:0] {
    RND_FLOOR = 2'b00,
    RND_HALF  = 2'b01,
    RND_CEIL  = 2'b10,
    RND_SPARE = 2'b11
  } rnd_mode_e;

  localparam int N_TERMS = 3;
  // Shift amounts whose powers of two add up to the coefficient 19.
  localparam int TERM_SHIFT [N_TERMS] = '{4, 1, 0};
endpackage

// File: rtl/ratio_scaler_terms.sv
module ratio_scaler_terms
  import ratio_scaler_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 13
) (
  input  logic [DATA_W-1:0] sample,
  output logic [SUM_W-1:0]  product
);
  localparam int PAD_W = SUM_W - DATA_W;

  logic [SUM_W-1:0] widened;
  logic [SUM_W-1:0] term [N_TERMS];

  assign widened = {{PAD_W{1'b0}}, sample};

  for (genvar g = 0; g < N_TERMS; g++) begin : g_term
    assign term[g] = widened << TERM_SHIFT[g];
  end

  always_comb begin
    product = '0;
    for (int i = 0; i < N_TERMS; i++) begin
      product = product + term[i];
    end
  end
endmodule

// File: rtl/ratio_scaler_round.sv
module ratio_scaler_round
  import ratio_scaler_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DROP_W = 5,
  localparam int SUM_W = DATA_W + DROP_W
) (
  input  logic [SUM_W-1:0]  product,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] quotient
);
  localparam logic [SUM_W-1:0] OFS_HALF = SUM_W'(1) << (DROP_W - 1);
  localparam logic [SUM_W-1:0] OFS_CEIL = (SUM_W'(1) << DROP_W) - SUM_W'(1);

  logic [SUM_W-1:0] offset;
  logic [SUM_W-1:0] biased;

  always_comb begin
    case (rnd_mode_e'(mode))
      RND_HALF: offset = OFS_HALF;
      RND_CEIL: offset = OFS_CEIL;
      default:  offset = '0;
    endcase
  end

  assign biased   = product + offset;
  assign quotient = biased[SUM_W-1:DROP_W];

  // R8: adding the rounding offset must never wrap the intermediate sum
  always_comb begin
    a_r8_sum_no_wrap: assert (biased >= product);
  end
endmodule

// File: rtl/ratio_scaler_reg.sv
module ratio_scaler_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              vld
);
  logic [DATA_W-1:0] q_nxt;
  logic              vld_nxt;

  always_comb begin
    q_nxt   = q;
    vld_nxt = load;
    if (load) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      q   <= q_nxt;
      vld <= vld_nxt;
    end
  end
endmodule

// File: rtl/ratio_scaler.sv
module ratio_scaler
  import ratio_scaler_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DROP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [1:0]        in_round,
  output logic [DATA_W-1:0] out_scaled,
  output logic              out_valid
);
  localparam int SUM_W = DATA_W + DROP_W;

  logic [SUM_W-1:0]  product;
  logic [DATA_W-1:0] quotient;

  ratio_scaler_terms #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_terms (
    .sample  (in_sample),
    .product (product)
  );

  ratio_scaler_round #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_round (
    .product  (product),
    .mode     (in_round),
    .quotient (quotient)
  );

  ratio_scaler_reg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (quotient),
    .q     (out_scaled),
    .vld   (out_valid)
  );

  // R6: the valid strobe trails the input strobe by exactly one edge
  a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r6_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7: idle cycles leave the result untouched
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_scaled));

  // R2: floor mode matches a plain multiply-and-shift reference
  a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_round == 2'b00) |=>
      (32'(out_scaled) == ((32'($past(in_sample)) * 32'd19) >> DROP_W)));

  // R8: the result never exceeds the largest reachable value
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_scaled <= DATA_W'(152));
endmodule

// File: tb/test_ratio_scaler.sv
`timescale 1ns/1ps
module test_ratio_scaler;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_sample;
  logic [1:0] in_round;
  logic [7:0] out_scaled;
  logic       out_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ratio_scaler i_ratio_scaler (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .in_round   (in_round),
    .out_scaled (out_scaled),
    .out_valid  (out_valid)
  );

  function automatic int ref_val(int x, int m);
    case (m)
      1:       return (x * 19 + 16) / 32;
      2:       return (x * 19 + 31) / 32;
      default: return (x * 19) / 32;
    endcase
  endfunction

  function automatic string req_of(int m);
    case (m)
      1:       return "R3";
      2:       return "R4";
      3:       return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = 8'd0;
    in_round  = 2'b00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_scaled", int'(out_scaled), 0);
    check("R1 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every sample in every select code; R6 valid checked each time
    for (int m = 0; m < 4; m++) begin
      for (int x = 0; x < 256; x++) begin
        in_valid  = 1'b1;
        in_sample = 8'(x);
        in_round  = 2'(m);
        @(negedge clk);
        check(req_of(m), int'(out_scaled), ref_val(x, m));
        check("R6 valid high", int'(out_valid), 1);
      end
    end

    // R8: largest case in ceiling mode
    in_valid = 1'b1; in_sample = 8'd255; in_round = 2'b10;
    @(negedge clk);
    check("R8 max ceil", int'(out_scaled), 152);

    // R7: idle cycle with new sample and mode must not change the result
    in_valid = 1'b0; in_sample = 8'd7; in_round = 2'b00;
    @(negedge clk);
    check("R7 hold", int'(out_scaled), 152);
    check("R6 valid low", int'(out_valid), 0);
    in_sample = 8'd200; in_round = 2'b01;
    @(negedge clk);
    check("R7 hold second", int'(out_scaled), 152);

    // R3: tie at x=16 (304/32 = 9.5) rounds up; floor gives 9
    in_valid = 1'b1; in_sample = 8'd16; in_round = 2'b01;
    @(negedge clk);
    check("R3 tie", int'(out_scaled), 10);
    in_round = 2'b00;
    @(negedge clk);
    check("R2 tie floor", int'(out_scaled), 9);
    in_valid = 1'b0;
    @(negedge clk);
    check("R6 single strobe", int'(out_valid), 0);

    // R1: asynchronous reset mid-run clears outputs
    in_valid = 1'b1; in_sample = 8'd100; in_round = 2'b10;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async out_scaled", int'(out_scaled), 0);
    check("R1 async out_valid", int'(out_valid), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule